// File: doc/BRIEF.md
# SPI Master Register Peripheral

This block is a bus-attached serial master. It has three word registers: an outbound data word, an inbound data word, and a control/status word. Software places a value in the outbound register. It then writes the control word with the start bit set. The block clocks the value out on the serial data line, most significant bit first. On each rising serial clock edge it captures one bit from the return line.

Each transfer is either 8 or 16 bits, chosen by a control bit. A busy flag in the control word lets software poll for completion. The inbound register is replaced in one step when the last bit is captured. The block drives no device-select line; a general-purpose output port elsewhere on the bus owns those lines.

The serial clock idles low and is derived from the system clock by an even divisor. Output data changes on the falling serial edge, and input data is captured on the rising edge.

Top module: `spim_periph`

## Requirements
- R1: Byte offset 0x4 holds the outbound data register, which is writable and reads back its stored value. Offset 0x8 holds the inbound data register, which is read-only. Offset 0xC holds the control/status word.
- R2: Writing the control word with bit 1 set while the block is idle starts a transfer of the outbound register contents, most significant bit first.
- R3: Control bit 0 reads 1 from the cycle after the start write until the final serial falling edge, and reads 0 otherwise.
- R4: Control bit 2 selects the transfer length. A 0 gives 8 bits taken from outbound bits [7:0]. A 1 gives 16 bits. The stored bit reads back at bit 2.
- R5: The inbound register holds the captured bits, first-captured bit as most significant. In 8-bit mode the upper bits are zero. The register changes only once per transfer, after the final bit is captured, and keeps its previous value during a transfer.
- R6: The serial clock is low whenever no transfer runs. Output data changes only while the serial clock is low. Input data is sampled on the rising serial edge. Output data is low when idle.
- R7: The serial clock period is CLK_DIV system clocks with equal high and low halves, so consecutive rising edges are CLK_DIV cycles apart.
- R8: A control write while busy has no effect: the transfer neither restarts nor lengthens, and the length bit keeps its value. Control bit 1 always reads 0.
- R9: After synchronous reset, all three registers read 0, and the serial clock and output data are low.
- R10: A read returns data one clock after the read strobe. Offsets other than the three mapped ones read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset within the peripheral window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A corrupted bit counter shows up at the serial clock pin within one transfer, as one rising edge too many or too few. It also shows up as an inbound value shifted by one place. A misloaded or misaligned shift register shows up on the first captured output bit, CLK_DIV/2 cycles after the start. A divider fault changes the spacing of rising edges from the first pair onward. A busy flag or a length bit that is wrongly updated becomes visible at the next control read, or as a restarted or lengthened transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int OFF_TXD  = 4;
  localparam int OFF_RXD  = 8;
  localparam int OFF_CTRL = 12;
  localparam int CB_BUSY  = 0;
  localparam int CB_GO    = 1;
  localparam int CB_WIDE  = 2;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W        = 16,
  parameter int NARROW_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         wide,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  input  logic         tick,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh_tx, sh_rx;
  logic [CW-1:0] bits_left;

  assign mosi = sh_tx[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sclk <= 1'b0; sh_tx <= '0; sh_rx <= '0;
      bits_left <= '0; done <= 1'b0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          sh_tx     <= wide ? tx_word : (tx_word << (W - NARROW_W));
          sh_rx     <= '0;
          bits_left <= wide ? CW'(W - 1) : CW'(NARROW_W - 1);
        end
      end else if (tick) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[W-2:0], miso};
          if (bits_left == '0) begin
            done    <= 1'b1;
            rx_word <= {sh_rx[W-2:0], miso};
          end
        end else begin
          sclk <= 1'b0;
          if (bits_left == '0) begin
            busy  <= 1'b0;
            sh_tx <= '0;
          end else begin
            sh_tx     <= {sh_tx[W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
          end
        end
      end
    end
  end

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && sclk && $past(sclk)) |-> $stable(mosi));
  p_done_in_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

// File: rtl/spim_periph.sv
module spim_periph #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int SPI_W   = 16,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  import spim_pkg::*;
  localparam int HALF = CLK_DIV / 2;
  localparam int NARROW_W = SPI_W / 2;

  logic [SPI_W-1:0] tx_q, rx_q, sh_rx;
  logic wide_q, busy, tick, sh_done, go;
  logic sel_tx, sel_rx, sel_ctrl;

  assign sel_tx   = reg_addr == ADDR_W'(OFF_TXD);
  assign sel_rx   = reg_addr == ADDR_W'(OFF_RXD);
  assign sel_ctrl = reg_addr == ADDR_W'(OFF_CTRL);
  assign go       = reg_wr && sel_ctrl && !busy && reg_wdata[CB_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0; rx_q <= '0; wide_q <= 1'b0;
    end else begin
      if (reg_wr && sel_tx) tx_q <= reg_wdata[SPI_W-1:0];
      if (reg_wr && sel_ctrl && !busy) wide_q <= reg_wdata[CB_WIDE];
      if (sh_done) rx_q <= sh_rx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (sel_tx)        reg_rdata <= DATA_W'(tx_q);
      else if (sel_rx)   reg_rdata <= DATA_W'(rx_q);
      else if (sel_ctrl) reg_rdata <= DATA_W'({wide_q, 1'b0, busy});
      else               reg_rdata <= '0;
    end
  end

  spim_clkgen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .tick(tick));

  spim_shifter #(.W(SPI_W), .NARROW_W(NARROW_W)) u_shift (
    .clk(clk), .rst(rst), .start(go), .wide(reg_wdata[CB_WIDE]),
    .tx_word(tx_q), .miso(spi_miso), .tick(tick), .busy(busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx_word(sh_rx));

  p_rx_atomic_r5: assert property (@(posedge clk) disable iff (rst)
    !sh_done |=> $stable(rx_q));
  p_width_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && sel_ctrl) |=> $stable(wide_q));
endmodule

// File: tb/spim_periph_tb.sv
`timescale 1ns/1ps
module spim_periph_tb;
  localparam int DIV = 4;
  logic clk = 0, rst = 1;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_sclk, spi_mosi, spi_miso;

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [15:0] sl_word = '0;
  int sl_bits = 0, sl_idx = 0;
  logic [15:0] exp_words[$];
  int exp_bits[$];
  logic [15:0] cap = '0;
  int nedge = 0, last_cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spim_periph #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  assign spi_miso = (sl_idx < sl_bits) ? sl_word[sl_bits-1-sl_idx] : 1'b0;
  always @(negedge spi_sclk) if (!rst) sl_idx <= sl_idx + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: capture each rising serial edge, pop expected word when complete
  always @(posedge spi_sclk) begin
    #1;
    if (exp_bits.size() == 0) begin
      check("R8 extra serial edge", 1, 0);
    end else begin
      if (nedge > 0) check("R7 rising edge spacing", cyc - last_cyc, DIV);
      last_cyc = cyc;
      cap = {cap[14:0], spi_mosi};
      nedge++;
      if (nedge == exp_bits[0]) begin
        check("R2 R4 R6 output bit stream", cap, exp_words[0]);
        void'(exp_words.pop_front());
        void'(exp_bits.pop_front());
        nedge = 0; cap = '0;
      end
    end
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_read(4'hC, v);
      if (v[0] == 1'b0) break;
    end
    check("R3 busy clears", {31'b0, v[0]}, 0);
  endtask

  // driver: pushes expectation then launches a transfer
  task automatic xfer(logic [15:0] tx, bit wide, logic [15:0] sw, logic [15:0] exp_rx);
    logic [31:0] v;
    int n;
    n = wide ? 16 : 8;
    sl_word = sw; sl_bits = n; sl_idx = 0;
    exp_words.push_back(wide ? tx : {8'h00, tx[7:0]});
    exp_bits.push_back(n);
    bus_write(4'h4, {16'h0, tx});
    bus_write(4'hC, {29'b0, wide, 2'b10});
    bus_read(4'hC, v);
    check("R3 busy during transfer", {31'b0, v[0]}, 1);
    check("R8 go bit reads 0", {31'b0, v[1]}, 0);
    check("R4 width bit readback", {31'b0, v[2]}, {31'b0, wide});
    wait_idle();
    check("R6 mosi idle low", {31'b0, spi_mosi}, 0);
    check("R6 sclk idle low", {31'b0, spi_sclk}, 0);
    bus_read(4'h8, v);
    check("R5 inbound word", v, {16'h0, exp_rx});
    check("R2 all bits sent", exp_bits.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R9 sclk after reset", {31'b0, spi_sclk}, 0);
    check("R9 mosi after reset", {31'b0, spi_mosi}, 0);
    bus_read(4'hC, v); check("R9 control after reset", v, 0);
    bus_read(4'h4, v); check("R9 outbound after reset", v, 0);
    bus_read(4'h8, v); check("R9 inbound after reset", v, 0);

    bus_write(4'h4, 32'hDEAD_1357);
    bus_read(4'h4, v); check("R1 outbound readback", v, 32'h0000_1357);
    bus_write(4'h8, 32'h0000_FFFF);
    bus_read(4'h8, v); check("R1 inbound read-only", v, 0);
    bus_read(4'h0, v); check("R10 unmapped offset", v, 0);

    xfer(16'h00A5, 0, 16'h003C, 16'h003C);
    xfer(16'h1234, 1, 16'hBEEF, 16'hBEEF);
    xfer(16'hFF81, 0, 16'h007E, 16'h007E);

    // start written while busy must be ignored; inbound must not change early
    sl_word = 16'h5AA5; sl_bits = 16; sl_idx = 0;
    exp_words.push_back(16'hC3C3); exp_bits.push_back(16);
    bus_write(4'h4, 32'h0000_C3C3);
    bus_write(4'hC, 32'h0000_0006);
    repeat (10) @(negedge clk);
    bus_write(4'h4, 32'h0000_0F0F);
    bus_write(4'hC, 32'h0000_0002);
    bus_read(4'h8, v); check("R5 inbound held mid-transfer", v, 32'h0000_007E);
    bus_read(4'hC, v); check("R8 width kept while busy", {31'b0, v[2]}, 1);
    wait_idle();
    repeat (3 * DIV) @(negedge clk);
    check("R8 no restart", {31'b0, spi_sclk}, 0);
    bus_read(4'hC, v); check("R8 still idle after ignored start", v, 32'h4);
    bus_read(4'h8, v); check("R5 inbound 16-bit", v, 32'h0000_5AA5);
    bus_read(4'h4, v); check("R1 outbound updated while busy", v, 32'h0000_0F0F);
    check("R2 queue drained", exp_bits.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule